// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag and Boost Window

This block sits at the digital heart of a frequency synthesizer loop. It watches two pulse trains: the divided reference and the divided oscillator feedback. It turns their relative timing into lead and lag correction drives for an external charge pump. The pump outputs are tri-state, so the pump floats whenever no phase error is present. A lock monitor watches how wide the correction pulses are and raises an active-low unlock flag once the loop has settled. A configuration bit can force that flag permanently low.

A fast-settle boost helps the loop filter charge after start-up or after a new divider setting. The boost drives a 5-bit level code with an enable for a fixed number of reference periods, two by default. An all-zero code leaves the boost output floating. When the run input is low the whole block is quiet: the pumps and the boost float, the flag is low, and all detector state is cleared.

Top module: `pfd_lock_boost`

## Requirements
- R1: A reference rising edge that comes g cycles before a feedback rising edge holds `pump_up_o` high for exactly g sampled cycles, starting the cycle after the reference edge. `pump_dn_o` stays low during that time.
- R2: A feedback rising edge that comes g cycles before a reference rising edge holds `pump_dn_o` high for exactly g cycles, and `pump_up_o` stays low.
- R3: `pump_up_o` and `pump_dn_o` are never high together. Coincident edges produce no pulse. `pump_oe_o` is high exactly when one of the two drives is high.
- R4: With `ld_en_i`=1, `unlock_n_o` goes high the cycle after the 4th consecutive reference edge whose preceding interval held no correction pulse wider than `err_limit_i` cycles. A pulse exactly `err_limit_i` cycles wide still counts as good.
- R5: A correction pulse wider than `err_limit_i` cycles drives `unlock_n_o` low after the next reference edge. Until that edge the flag keeps its value.
- R6: While `ld_en_i`=0, `unlock_n_o` is low from the next cycle on.
- R7: A rising `run_i` with a nonzero `boost_code_i` sets `boost_oe_o` high and presents the captured code on `boost_code_o` from the next cycle. Both return to 0 after the 2nd reference edge that follows.
- R8: A `load_done_i` strobe while running restarts the boost window. If it falls in the same cycle as a reference edge, that edge is not counted toward the window.
- R9: A boost code of 0 at the trigger leaves `boost_oe_o` low. `boost_oe_o` is never high with `boost_code_o` equal to 0.
- R10: With `run_i` low, from the next cycle `pump_oe_o`, both pump drives, `boost_oe_o` and `unlock_n_o` are 0. The lock history restarts from zero.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = operate, 0 = standby |
| ld_en_i | input | 1 | 1 = unlock flag active, 0 = flag held low |
| err_limit_i | input | 8 | Widest correction pulse, in cycles, still treated as locked |
| boost_code_i | input | 5 | Boost level code; 0 disables the boost |
| load_done_i | input | 1 | One-cycle strobe: new settings were written |
| ref_i | input | 1 | Divided reference pulse train |
| fb_i | input | 1 | Divided feedback pulse train |
| pump_up_o | output | 1 | Lead-correction drive |
| pump_dn_o | output | 1 | Lag-correction drive |
| pump_oe_o | output | 1 | Pump output enable (0 = float) |
| unlock_n_o | output | 1 | 0 = unlocked or flag disabled |
| boost_code_o | output | 5 | Boost level while enabled, else 0 |
| boost_oe_o | output | 1 | Boost output enable (0 = float) |

## Verification
Two functions can fall in the same cycle. A settings-written strobe can arrive in the very cycle the boost window would count a reference edge. The restart must win, and the edge must not shorten the new window. The bench lines the strobe up with a reference pulse midway through an active window. It then requires the boost to stay on after the next reference edge and to go off only after the one after that. A second coincidence is the two input edges arriving together, which must leave both pump drives low and must count as a good comparison for the lock monitor.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    typedef enum logic [0:0] {
        BST_IDLE  = 1'b0,
        BST_DRIVE = 1'b1
    } bst_state_e;

    function automatic logic [8:0] sat_inc9(input logic [8:0] v);
        return (&v) ? v : v + 9'd1;
    endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  ref_i,
    input  logic  fb_i,
    output pump_t pump_o,
    output logic  ref_edge_o
);
    logic  ref_q, fb_q;
    logic  fb_edge;
    pump_t st_q, st_nx;

    assign ref_edge_o = ref_i & ~ref_q;
    assign fb_edge    = fb_i & ~fb_q;

    always_comb begin
        st_nx.up = st_q.up | ref_edge_o;
        st_nx.dn = st_q.dn | fb_edge;
        if (!run || (st_nx.up && st_nx.dn)) begin
            st_nx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            fb_q  <= 1'b0;
            st_q  <= '0;
        end else begin
            ref_q <= ref_i;
            fb_q  <= fb_i;
            st_q  <= st_nx;
        end
    end

    assign pump_o = st_q;
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
    import pfd_pkg::*;
#(
    parameter int ERR_W  = 8,
    parameter int LOCK_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ld_en,
    input  logic [ERR_W-1:0] err_limit,
    input  pump_t            pump,
    input  logic             ref_edge,
    output logic             unlock_n
);
    localparam int CNT_W = $clog2(LOCK_N + 1);

    logic [8:0]       width_q, width_nx;
    logic             exceed, bad_q;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             active;

    assign active = pump.up | pump.dn;

    always_comb begin
        width_nx = active ? sat_inc9(width_q) : 9'd0;
        exceed   = active && (width_nx > 9'(err_limit));
        cnt_nx   = cnt_q;
        if (!run) begin
            cnt_nx = '0;
        end else if (ref_edge) begin
            if (bad_q || exceed)                cnt_nx = '0;
            else if (cnt_q != CNT_W'(LOCK_N))   cnt_nx = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q  <= '0;
            bad_q    <= 1'b0;
            cnt_q    <= '0;
            unlock_n <= 1'b0;
        end else begin
            width_q  <= run ? width_nx : 9'd0;
            if (!run || ref_edge) bad_q <= 1'b0;
            else                  bad_q <= bad_q | exceed;
            cnt_q    <= cnt_nx;
            unlock_n <= run && ld_en && (cnt_nx == CNT_W'(LOCK_N));
        end
    end
endmodule

// File: rtl/boost_window.sv
module boost_window
    import pfd_pkg::*;
#(
    parameter int CODE_W  = 5,
    parameter int PERIODS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load_done,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ref_edge,
    output logic [CODE_W-1:0] code_o,
    output logic              oe_o
);
    localparam int PCNT_W = $clog2(PERIODS + 1);

    bst_state_e        st_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [CODE_W-1:0] code_q;
    logic              run_q;
    logic              trigger;

    assign trigger = run && (!run_q || load_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BST_IDLE;
            pcnt_q <= '0;
            code_q <= '0;
            run_q  <= 1'b0;
        end else begin
            run_q <= run;
            if (!run) begin
                st_q <= BST_IDLE;
            end else if (trigger) begin
                pcnt_q <= '0;
                code_q <= code_i;
                st_q   <= (code_i != '0) ? BST_DRIVE : BST_IDLE;
            end else if (st_q == BST_DRIVE && ref_edge) begin
                if (pcnt_q == PCNT_W'(PERIODS - 1)) st_q <= BST_IDLE;
                else                                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    assign oe_o   = (st_q == BST_DRIVE);
    assign code_o = oe_o ? code_q : '0;
endmodule

// File: rtl/pfd_lock_boost.sv
module pfd_lock_boost
    import pfd_pkg::*;
#(
    parameter int CODE_W  = 5,
    parameter int ERR_W   = 8,
    parameter int LOCK_N  = 4,
    parameter int PERIODS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              ld_en_i,
    input  logic [ERR_W-1:0]  err_limit_i,
    input  logic [CODE_W-1:0] boost_code_i,
    input  logic              load_done_i,
    input  logic              ref_i,
    input  logic              fb_i,
    output logic              pump_up_o,
    output logic              pump_dn_o,
    output logic              pump_oe_o,
    output logic              unlock_n_o,
    output logic [CODE_W-1:0] boost_code_o,
    output logic              boost_oe_o
);
    pump_t pump;
    logic  ref_edge;

    pfd_core u_core (
        .clk(clk), .rst(rst), .run(run_i),
        .ref_i(ref_i), .fb_i(fb_i),
        .pump_o(pump), .ref_edge_o(ref_edge)
    );

    lock_monitor #(.ERR_W(ERR_W), .LOCK_N(LOCK_N)) u_lock (
        .clk(clk), .rst(rst), .run(run_i), .ld_en(ld_en_i),
        .err_limit(err_limit_i), .pump(pump), .ref_edge(ref_edge),
        .unlock_n(unlock_n_o)
    );

    boost_window #(.CODE_W(CODE_W), .PERIODS(PERIODS)) u_boost (
        .clk(clk), .rst(rst), .run(run_i), .load_done(load_done_i),
        .code_i(boost_code_i), .ref_edge(ref_edge),
        .code_o(boost_code_o), .oe_o(boost_oe_o)
    );

    assign pump_up_o = pump.up;
    assign pump_dn_o = pump.dn;
    assign pump_oe_o = pump.up | pump.dn;
endmodule

// File: rtl/pfd_lock_boost_chk.sv
module pfd_lock_boost_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              run_i,
    input logic              ld_en_i,
    input logic              load_done_i,
    input logic [CODE_W-1:0] boost_code_i,
    input logic              pump_up_o,
    input logic              pump_dn_o,
    input logic              pump_oe_o,
    input logic              unlock_n_o,
    input logic [CODE_W-1:0] boost_code_o,
    input logic              boost_oe_o
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(pump_up_o && pump_dn_o)); // R3
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst) !run_i |=> (!pump_oe_o && !boost_oe_o && !unlock_n_o)); // R10
    AST_LD_OFF: assert property (@(posedge clk) disable iff (rst) !ld_en_i |=> !unlock_n_o); // R6
    AST_BOOST_NONZERO: assert property (@(posedge clk) disable iff (rst) boost_oe_o |-> (boost_code_o != '0)); // R9
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst) (run_i && load_done_i && boost_code_i != '0) |=> (boost_oe_o && boost_code_o == $past(boost_code_i))); // R8
endmodule

bind pfd_lock_boost pfd_lock_boost_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .run_i(run_i), .ld_en_i(ld_en_i),
    .load_done_i(load_done_i), .boost_code_i(boost_code_i),
    .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .pump_oe_o(pump_oe_o),
    .unlock_n_o(unlock_n_o), .boost_code_o(boost_code_o), .boost_oe_o(boost_oe_o)
);

// File: tb/pfd_lock_boost_bench.sv
module pfd_lock_boost_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_i = 1'b0, ld_en_i = 1'b1, load_done_i = 1'b0;
    logic       ref_i = 1'b0, fb_i = 1'b0;
    logic [7:0] err_limit_i = 8'd3;
    logic [4:0] boost_code_i = 5'd0;
    logic       pump_up_o, pump_dn_o, pump_oe_o, unlock_n_o, boost_oe_o;
    logic [4:0] boost_code_o;

    int n_chk = 0, n_fail = 0;
    int up_cnt, dn_cnt, both_cnt, oe_bad;

    always #4 clk = ~clk;

    pfd_lock_boost u_pfd_lock_boost (
        .clk(clk), .rst(rst), .run_i(run_i), .ld_en_i(ld_en_i),
        .err_limit_i(err_limit_i), .boost_code_i(boost_code_i),
        .load_done_i(load_done_i), .ref_i(ref_i), .fb_i(fb_i),
        .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .pump_oe_o(pump_oe_o),
        .unlock_n_o(unlock_n_o), .boost_code_o(boost_code_o), .boost_oe_o(boost_oe_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One comparison interval of len cycles; the leading edge at cycle 0,
    // the trailing one at cycle gap. Counts drive cycles sampled after each edge.
    task automatic period(input int gap, input bit ref_first, input int len, input bit load_at0);
        up_cnt = 0; dn_cnt = 0; both_cnt = 0; oe_bad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ref_i       = ref_first ? (i == 0) : (i == gap);
            fb_i        = ref_first ? (i == gap) : (i == 0);
            load_done_i = load_at0 && (i == 0);
            @(posedge clk); #1;
            up_cnt   += int'(pump_up_o);
            dn_cnt   += int'(pump_dn_o);
            both_cnt += int'(pump_up_o && pump_dn_o);
            oe_bad   += int'(pump_oe_o != (pump_up_o || pump_dn_o));
        end
        @(negedge clk);
        ref_i = 1'b0; fb_i = 1'b0; load_done_i = 1'b0;
    endtask

    task automatic t_reset;
        chk(!pump_up_o && !pump_dn_o && !pump_oe_o, "R11 pumps", int'(pump_oe_o), 0);
        chk(!unlock_n_o && !boost_oe_o && boost_code_o == 0, "R11 flag/boost", int'(boost_oe_o), 0);
    endtask

    task automatic t_lead_lag;
        period(3, 1'b1, 8, 1'b0);
        chk(up_cnt == 3, "R1 lead width", up_cnt, 3);
        chk(dn_cnt == 0, "R1 no lag", dn_cnt, 0);
        period(5, 1'b0, 8, 1'b0);
        chk(dn_cnt == 5, "R2 lag width", dn_cnt, 5);
        chk(up_cnt == 0, "R2 no lead", up_cnt, 0);
        period(0, 1'b1, 4, 1'b0);
        chk(up_cnt + dn_cnt == 0, "R3 coincident edges", up_cnt + dn_cnt, 0);
        chk(both_cnt == 0 && oe_bad == 0, "R3 overlap/enable", both_cnt + oe_bad, 0);
    endtask

    task automatic t_lock;
        // Restart history through standby
        @(negedge clk); run_i = 1'b0;
        @(negedge clk); run_i = 1'b1;
        for (int k = 0; k < 3; k++) period(3, 1'b1, 10, 1'b0);
        chk(!unlock_n_o, "R4 still unlocked after 3", int'(unlock_n_o), 0);
        period(3, 1'b1, 10, 1'b0);
        chk(unlock_n_o, "R4 locked after 4 (width=limit)", int'(unlock_n_o), 1);
        period(6, 1'b1, 10, 1'b0);
        chk(unlock_n_o, "R5 holds until next ref edge", int'(unlock_n_o), 1);
        period(1, 1'b1, 10, 1'b0);
        chk(!unlock_n_o, "R5 drops after wide pulse", int'(unlock_n_o), 0);
        for (int k = 0; k < 4; k++) period(0, 1'b1, 6, 1'b0);
        chk(unlock_n_o, "R4 relock", int'(unlock_n_o), 1);
        @(negedge clk); ld_en_i = 1'b0;
        @(negedge clk);
        chk(!unlock_n_o, "R6 flag disabled", int'(unlock_n_o), 0);
        period(0, 1'b1, 6, 1'b0);
        chk(!unlock_n_o, "R6 stays low", int'(unlock_n_o), 0);
        @(negedge clk); ld_en_i = 1'b1;
    endtask

    task automatic t_boost;
        @(negedge clk); run_i = 1'b0; boost_code_i = 5'h13;
        @(negedge clk); run_i = 1'b1;
        @(posedge clk); #1;
        chk(boost_oe_o && boost_code_o == 5'h13, "R7 boost on", int'(boost_code_o), 19);
        period(0, 1'b1, 5, 1'b0);
        chk(boost_oe_o, "R7 on after 1st ref", int'(boost_oe_o), 1);
        period(0, 1'b1, 5, 1'b0);
        chk(!boost_oe_o && boost_code_o == 0, "R7 off after 2nd ref", int'(boost_oe_o), 0);
        // Restart on a write strobe coinciding with a ref edge
        @(negedge clk); load_done_i = 1'b1; boost_code_i = 5'h07;
        @(negedge clk); load_done_i = 1'b0;
        period(0, 1'b1, 5, 1'b0);
        chk(boost_oe_o && boost_code_o == 5'h07, "R8 window after strobe", int'(boost_code_o), 7);
        period(0, 1'b1, 5, 1'b1);
        chk(boost_oe_o, "R8 coincident edge not counted", int'(boost_oe_o), 1);
        period(0, 1'b1, 5, 1'b0);
        chk(boost_oe_o, "R8 one edge counted", int'(boost_oe_o), 1);
        period(0, 1'b1, 5, 1'b0);
        chk(!boost_oe_o, "R8 window ends", int'(boost_oe_o), 0);
        // Zero code
        @(negedge clk); run_i = 1'b0; boost_code_i = 5'd0;
        @(negedge clk); run_i = 1'b1;
        @(posedge clk); #1;
        chk(!boost_oe_o && boost_code_o == 0, "R9 zero code float", int'(boost_oe_o), 0);
        @(negedge clk); load_done_i = 1'b1;
        @(negedge clk); load_done_i = 1'b0;
        chk(!boost_oe_o, "R9 zero code on strobe", int'(boost_oe_o), 0);
    endtask

    task automatic t_standby;
        for (int k = 0; k < 4; k++) period(0, 1'b1, 6, 1'b0);
        boost_code_i = 5'h1F;
        @(negedge clk); load_done_i = 1'b1; ref_i = 1'b1;
        @(negedge clk); load_done_i = 1'b0; ref_i = 1'b0;
        chk(pump_up_o && boost_oe_o && unlock_n_o, "R10 precondition", int'(pump_up_o), 1);
        run_i = 1'b0;
        @(posedge clk); #1;
        chk(!pump_oe_o && !pump_up_o && !pump_dn_o, "R10 pumps float", int'(pump_oe_o), 0);
        chk(!boost_oe_o && !unlock_n_o, "R10 boost/flag", int'(boost_oe_o) + int'(unlock_n_o), 0);
        @(negedge clk); boost_code_i = 5'd0; run_i = 1'b1;
        period(0, 1'b1, 6, 1'b0);
        chk(!unlock_n_o, "R10 lock history cleared", int'(unlock_n_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_i = 1'b1;
        @(negedge clk);
        t_lead_lag();
        t_lock();
        t_boost();
        t_standby();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule